// File: doc/BRIEF.md
# Presence-Detect EEPROM Slave

This block is a 256-byte configuration memory that a host reads and writes over a two-wire serial bus. It uses a clock line and an open-drain data line. The block samples both lines with its own system clock. It never drives the data line high: it only pulls the line low, through `sdaPullLow`. Three strap inputs complete its 7-bit bus address. A host addresses the device and sets an internal byte pointer with a word-address byte. It then either writes one data byte, or issues a repeated START and streams bytes out. The pointer advances after every byte.

At reset the lower 128 bytes hold a module description image. The first bytes of that image come from a parameter, and byte 63 is the checksum of bytes 0 to 62. The upper 128 bytes start erased at 0xFF and always accept writes. The lower half accepts writes only until a one-time lock is applied. After the lock, a write to the lower half is still acknowledged, but it is discarded. The block keeps checking the stored checksum byte against the current contents and raises a flag when the two disagree.

Top module: `spdEeprom`

## Requirements
- R1: After reset `sdaPullLow` is 0, `checksumBad` is 0, the lower half holds the parameter image and every upper-half byte (addresses 0x80 to 0xFF) reads 0xFF.
- R2: The device acknowledges only the 7-bit address made of the bits 1010 followed by `strapAddr[2]`, `strapAddr[1]`, `strapAddr[0]`, sent MSB first with the R/W bit last (0 = write, 1 = read). It acknowledges by holding the data line low during the ninth clock. For any other address the line stays released.
- R3: With default parameters, bytes 0 to 4 read 0x80, 0x08, 0x07, 0x0D, 0x0A. Byte 63 reads the low 8 bits of the sum of bytes 0 to 62, which is 0xA6.
- R4: A random read is a write-addressed word-address byte, a repeated START, and a read address. It returns the byte at that word address, MSB first. Each data bit is set up while the clock is low and held stable through the whole clock-high phase.
- R5: In a sequential read the pointer advances by one after each byte and wraps from 0xFF to 0x00. A master not-acknowledge ends the read, and the data line is released from then on.
- R6: A byte write to an upper-half address stores the byte. Afterwards the pointer holds the next address, so a read with no word address returns the following byte.
- R7: Only one data byte is accepted per write transaction. A second data byte is not acknowledged and is not stored.
- R8: Before the lock, lower-half addresses are writable.
- R9: The lock is sticky until reset. Once locked, a lower-half write is acknowledged but leaves the contents unchanged, and upper-half writes still take effect.
- R10: If `lockReq` is high in the same cycle as an internal byte-write commit to the lower half, that write is rejected.
- R11: `checksumBad` is 1 whenever stored byte 63 differs from the 8-bit sum of bytes 0 to 62, and it returns to 0 once they agree again.
- R12: START is a falling data line and STOP is a rising data line, each while the clock is high. A STOP in the middle of a byte returns the bus logic to idle, and the next transaction works normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Level of the bus clock line |
| sdaIn | input | 1 | Level of the bus data line |
| strapAddr | input | 3 | Board straps, low three bits of the device address |
| lockReq | input | 1 | Pulse that permanently write-protects the lower half |
| sdaPullLow | output | 1 | 1 pulls the data line low (open-drain driver enable) |
| checksumBad | output | 1 | Stored byte 63 disagrees with the sum of bytes 0 to 62 |

## Verification
Two functions can meet in one clock: a lock request and the commit of a lower-half byte write. The commit happens on the cycle the block recognises the clock falling after the eighth data bit. The bench places a one-cycle `lockReq` pulse exactly on that cycle, two synchroniser stages after it drops the clock line. It then judges the result at the ports. The write must still be acknowledged, and reading the byte back must show its earlier value, because the lock wins.

// File: rtl/spd_pkg.sv
package spd_pkg;

  localparam int BYTE_W = 8;
  localparam int HEAD_MAX = 8;

  // Strobes issued by the bus controller to the storage datapath.
  typedef struct packed {
    logic shiftRx;
    logic loadPtr;
    logic writeMem;
    logic loadTx;
    logic shiftTx;
  } busStrb_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_DEVACK,
    S_ADDR,
    S_ADDRACK,
    S_DATA,
    S_DATAACK,
    S_TX,
    S_TXACK,
    S_WAIT
  } busState_t;

  function automatic logic [BYTE_W-1:0] headByte(int idx, logic [BYTE_W*HEAD_MAX-1:0] head,
                                                  int headLen);
    if (idx < headLen && idx < HEAD_MAX) return head[BYTE_W*idx +: BYTE_W];
    return '0;
  endfunction

  // Reset image: parameter header, zero padding, checksum byte, erased upper half.
  function automatic logic [BYTE_W-1:0] imageByte(int idx, logic [BYTE_W*HEAD_MAX-1:0] head,
                                                   int headLen, int csumPos, int lowerLen,
                                                   logic [BYTE_W-1:0] fill);
    logic [BYTE_W-1:0] sumV;
    sumV = '0;
    if (idx >= lowerLen) return fill;
    if (idx == csumPos) begin
      for (int k = 0; k < HEAD_MAX; k++) begin
        if (k < csumPos) sumV = sumV + headByte(k, head, headLen);
      end
      return sumV;
    end
    if (idx < csumPos) return headByte(idx, head, headLen);
    return '0;
  endfunction

endpackage

// File: rtl/spdSync.sv
module spdSync #(
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stageQ;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ <= {STAGES{RESET_VAL}};
        else       stageQ <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ <= {STAGES{RESET_VAL}};
        else       stageQ <= {stageQ[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/spdBusCtrl.sv
module spdBusCtrl
  import spd_pkg::*;
#(
  parameter int DEV_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclQ,
  input  logic              sdaQ,
  input  logic [DEV_W-1:0]  devAddr,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txBit,
  output busStrb_t          strb,
  output logic              sdaPullLow,
  output logic              stopEvt,
  output logic              fsmIdle
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  busState_t        stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic             rwQ, rwD;
  logic             mAckQ, mAckD;
  logic             sclP, sdaP;
  logic             sclRise, sclFall, startEvt, byteDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclP <= sclQ;
      sdaP <= sdaQ;
    end
  end

  always_comb begin
    sclRise  = sclQ & ~sclP;
    sclFall  = ~sclQ & sclP;
    startEvt = sclQ & sclP & sdaP & ~sdaQ;
    stopEvt  = sclQ & sclP & ~sdaP & sdaQ;
    byteDone = (cntQ == CNT_W'(BYTE_W));
  end

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    rwD    = rwQ;
    mAckD  = mAckQ;
    strb   = '0;
    if (stopEvt) begin
      stateD = S_IDLE;
      cntD   = '0;
    end else if (startEvt) begin
      stateD = S_DEV;
      cntD   = '0;
    end else begin
      case (stateQ)
        S_DEV, S_ADDR, S_DATA: begin
          if (sclRise && !byteDone) begin
            strb.shiftRx = 1'b1;
            cntD         = cntQ + CNT_W'(1);
          end else if (sclFall && byteDone) begin
            cntD = '0;
            if (stateQ == S_DEV) begin
              if (rxByte[BYTE_W-1:1] == devAddr) begin
                rwD    = rxByte[0];
                stateD = S_DEVACK;
              end else begin
                stateD = S_WAIT;
              end
            end else if (stateQ == S_ADDR) begin
              strb.loadPtr = 1'b1;
              stateD       = S_ADDRACK;
            end else begin
              strb.writeMem = 1'b1;
              stateD        = S_DATAACK;
            end
          end
        end
        S_DEVACK: begin
          if (sclFall) begin
            if (rwQ) begin
              strb.loadTx = 1'b1;
              stateD      = S_TX;
            end else begin
              stateD = S_ADDR;
            end
          end
        end
        S_ADDRACK: if (sclFall) stateD = S_DATA;
        S_DATAACK: if (sclFall) stateD = S_WAIT;
        S_TX: begin
          if (sclRise) begin
            cntD = cntQ + CNT_W'(1);
          end else if (sclFall) begin
            if (byteDone) begin
              cntD   = '0;
              stateD = S_TXACK;
            end else begin
              strb.shiftTx = 1'b1;
            end
          end
        end
        S_TXACK: begin
          if (sclRise) begin
            mAckD = ~sdaQ;
          end else if (sclFall) begin
            if (mAckQ) begin
              strb.loadTx = 1'b1;
              stateD      = S_TX;
            end else begin
              stateD = S_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      cntQ   <= '0;
      rwQ    <= 1'b0;
      mAckQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
      rwQ    <= rwD;
      mAckQ  <= mAckD;
    end
  end

  always_comb begin
    sdaPullLow = (stateQ == S_DEVACK) || (stateQ == S_ADDRACK) || (stateQ == S_DATAACK) ||
                 ((stateQ == S_TX) && !txBit);
    fsmIdle    = (stateQ == S_IDLE);
  end

endmodule

// File: rtl/spdDatapath.sv
module spdDatapath
  import spd_pkg::*;
#(
  parameter int                         DEPTH      = 256,
  parameter int                         CSUM_POS   = 63,
  parameter logic [BYTE_W*HEAD_MAX-1:0] HEAD_BYTES = '0,
  parameter int                         HEAD_LEN   = 0,
  parameter logic [BYTE_W-1:0]          UPPER_FILL = 8'hFF,
  localparam int                        ADDR_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrb_t          strb,
  input  logic              sdaQ,
  input  logic              lockReq,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txBit,
  output logic              checksumBad,
  output logic [ADDR_W-1:0] curPtr,
  output logic              lockedQ
);

  localparam int LOWER_LEN = DEPTH / 2;

  logic [BYTE_W-1:0] memQ [DEPTH];
  logic [ADDR_W-1:0] ptrQ;
  logic [BYTE_W-1:0] rxQ, txQ;
  logic [BYTE_W-1:0] sumC;
  logic              wrAllowed;
  logic              badQ;

  // Upper half is always open; lower half closes on the lock, even one arriving now.
  assign wrAllowed = ptrQ[ADDR_W-1] | ~(lockedQ | lockReq);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        memQ[i] <= imageByte(i, HEAD_BYTES, HEAD_LEN, CSUM_POS, LOWER_LEN, UPPER_FILL);
      end
    end else if (strb.writeMem && wrAllowed) begin
      memQ[ptrQ] <= rxQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ    <= '0;
      rxQ     <= '0;
      txQ     <= '1;
      lockedQ <= 1'b0;
      badQ    <= 1'b0;
    end else begin
      lockedQ <= lockedQ | lockReq;
      badQ    <= (sumC != memQ[CSUM_POS]);
      if (strb.shiftRx) rxQ <= {rxQ[BYTE_W-2:0], sdaQ};
      if (strb.loadPtr) begin
        ptrQ <= rxQ[ADDR_W-1:0];
      end else if (strb.writeMem) begin
        ptrQ <= ptrQ + ADDR_W'(1);
      end else if (strb.loadTx) begin
        ptrQ <= ptrQ + ADDR_W'(1);
      end
      if (strb.loadTx)       txQ <= memQ[ptrQ];
      else if (strb.shiftTx) txQ <= {txQ[BYTE_W-2:0], 1'b1};
    end
  end

  always_comb begin
    sumC = '0;
    for (int k = 0; k < CSUM_POS; k++) sumC = sumC + memQ[k];
  end

  assign rxByte      = rxQ;
  assign txBit       = txQ[BYTE_W-1];
  assign checksumBad = badQ;
  assign curPtr      = ptrQ;

endmodule

// File: rtl/spdEeprom.sv
module spdEeprom
  import spd_pkg::*;
#(
  parameter int                         DEPTH       = 256,
  parameter int                         CSUM_POS    = 63,
  parameter int                         SYNC_STAGES = 2,
  parameter logic [3:0]                 DEV_PREFIX  = 4'b1010,
  parameter logic [BYTE_W*HEAD_MAX-1:0] HEAD_BYTES  = 64'h0000_000A_0D07_0880,
  parameter int                         HEAD_LEN    = 5,
  parameter logic [BYTE_W-1:0]          UPPER_FILL  = 8'hFF
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapAddr,
  input  logic       lockReq,
  output logic       sdaPullLow,
  output logic       checksumBad
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int DEV_W  = 7;

  logic              sclQ, sdaQ;
  busStrb_t          strb;
  logic [BYTE_W-1:0] rxByte;
  logic              txBit;
  logic [ADDR_W-1:0] curPtr;
  logic              lockedQ;
  logic              stopEvt, fsmIdle;
  logic [DEV_W-1:0]  devAddr;

  assign devAddr = {DEV_PREFIX, strapAddr};

  spdSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sclSync (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclQ)
  );

  spdSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sdaSync (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaQ)
  );

  spdBusCtrl #(.DEV_W(DEV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclQ(sclQ), .sdaQ(sdaQ), .devAddr(devAddr),
    .rxByte(rxByte), .txBit(txBit), .strb(strb), .sdaPullLow(sdaPullLow),
    .stopEvt(stopEvt), .fsmIdle(fsmIdle)
  );

  spdDatapath #(
    .DEPTH(DEPTH), .CSUM_POS(CSUM_POS), .HEAD_BYTES(HEAD_BYTES),
    .HEAD_LEN(HEAD_LEN), .UPPER_FILL(UPPER_FILL)
  ) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaQ(sdaQ), .lockReq(lockReq),
    .rxByte(rxByte), .txBit(txBit), .checksumBad(checksumBad),
    .curPtr(curPtr), .lockedQ(lockedQ)
  );

endmodule

// File: rtl/spdEepromChecker.sv
module spdEepromChecker
  import spd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclLevel,
  input logic              sdaPullLow,
  input busStrb_t          strb,
  input logic [ADDR_W-1:0] curPtr,
  input logic              lockedQ,
  input logic              stopEvt,
  input logic              fsmIdle
);

  // R4
  sda_steady_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !sclLevel);

  // R5
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadTx || strb.writeMem) |=> curPtr == ADDR_W'($past(curPtr) + ADDR_W'(1)));

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockedQ |=> lockedQ);

  // R12
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopEvt |=> fsmIdle);

  // R6
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shiftRx, strb.loadPtr, strb.writeMem, strb.loadTx, strb.shiftTx}));

endmodule

bind spdEeprom spdEepromChecker #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .sclLevel(sclQ), .sdaPullLow(sdaPullLow), .strb(strb),
  .curPtr(curPtr), .lockedQ(lockedQ), .stopEvt(stopEvt), .fsmIdle(fsmIdle)
);

// File: tb/spdEeprom_test.sv
module spdEeprom_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_WR = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_RD = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic lockReq = 1'b0;
  logic [2:0] strap = STRAP;
  logic sdaBus, sdaPullLow, checksumBad;

  assign sdaBus = sdaM & ~sdaPullLow;
  always #(CLK_PERIOD / 2) clk = ~clk;

  spdEeprom uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .strapAddr(strap),
    .lockReq(lockReq), .sdaPullLow(sdaPullLow), .checksumBad(checksumBad)
  );

  typedef struct {
    logic [7:0] val;
    string      tag;
  } expItem_t;

  expItem_t   expQ[$];
  logic [7:0] obsQ[$];
  int checks = 0;
  int errors = 0;
  int glitches = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Monitor: pops observed bytes against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      while (obsQ.size() > 0) begin
        logic [7:0] got;
        got = obsQ.pop_front();
        if (expQ.size() == 0) begin
          check(1'b0, "R5 unexpected byte", got, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(got === e.val, e.tag, got, e.val);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R12 watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic waitC(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectByte(input logic [7:0] v, input string tag);
    expItem_t e;
    e.val = v;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic clockBit(input logic b, input bit lockAtFall, output logic seen);
    sdaM = b;
    waitC(4);
    sclM = 1'b1;
    waitC(3);
    seen = sdaBus;
    waitC(3);
    if (sdaBus !== seen) glitches++;
    waitC(2);
    sclM = 1'b0;
    if (lockAtFall) begin
      waitC(2);
      lockReq = 1'b1;
      waitC(1);
      lockReq = 1'b0;
      waitC(1);
    end else begin
      waitC(4);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1;
    waitC(4);
    sclM = 1'b1;
    waitC(6);
    sdaM = 1'b0;
    waitC(6);
    sclM = 1'b0;
    waitC(4);
  endtask

  task automatic busStop();
    sdaM = 1'b0;
    waitC(4);
    sclM = 1'b1;
    waitC(6);
    sdaM = 1'b1;
    waitC(8);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit lockLast, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], lockLast && (i == 0), s);
    clockBit(1'b1, 1'b0, s);
    acked = (s == 1'b0);
  endtask

  task automatic recvByte(input bit masterAck, output logic [7:0] v);
    logic s;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      clockBit(1'b1, 1'b0, s);
      v = {v[6:0], s};
    end
    clockBit(masterAck ? 1'b0 : 1'b1, 1'b0, s);
  endtask

  task automatic readSeq(input logic [7:0] addr, input int n);
    bit a;
    logic [7:0] v;
    busStart();
    sendByte(DEV_WR, 1'b0, a);
    check(a, "R2 write address ack", a, 1);
    sendByte(addr, 1'b0, a);
    check(a, "R4 word address ack", a, 1);
    busStart();
    sendByte(DEV_RD, 1'b0, a);
    check(a, "R2 read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, v);
      obsQ.push_back(v);
    end
    busStop();
    check(sdaPullLow == 1'b0, "R5 line released after nack", sdaPullLow, 0);
  endtask

  task automatic currentRead();
    bit a;
    logic [7:0] v;
    busStart();
    sendByte(DEV_RD, 1'b0, a);
    check(a, "R6 current read ack", a, 1);
    recvByte(1'b0, v);
    obsQ.push_back(v);
    busStop();
  endtask

  task automatic writeByte(input logic [7:0] addr, input logic [7:0] data, input bit lockLast,
                           input string tag);
    bit a;
    busStart();
    sendByte(DEV_WR, 1'b0, a);
    check(a, "R2 write address ack", a, 1);
    sendByte(addr, 1'b0, a);
    check(a, "R4 word address ack", a, 1);
    sendByte(data, lockLast, a);
    check(a, tag, a, 1);
    busStop();
  endtask

  initial begin
    bit a;
    logic s;
    waitC(3);
    rstN = 1'b1;
    waitC(4);

    // R1 reset state
    check(sdaPullLow == 1'b0, "R1 pull released", sdaPullLow, 0);
    check(checksumBad == 1'b0, "R1 checksum flag clear", checksumBad, 0);

    // R3 image, R5 sequential, R4 bit stability
    expectByte(8'h80, "R3 byte0");
    expectByte(8'h08, "R3 byte1");
    expectByte(8'h07, "R3 byte2");
    expectByte(8'h0D, "R3 byte3");
    expectByte(8'h0A, "R3 byte4");
    readSeq(8'h00, 5);
    expectByte(8'hA6, "R3 checksum byte63");
    readSeq(8'd63, 1);
    expectByte(8'hFF, "R1 upper erased");
    readSeq(8'h80, 1);

    // R2 wrong device address is not acknowledged
    busStart();
    sendByte({4'b1010, 3'b000, 1'b0}, 1'b0, a);
    check(!a, "R2 foreign address nack", a, 0);
    busStop();
    busStart();
    sendByte({4'b1011, STRAP, 1'b1}, 1'b0, a);
    check(!a, "R2 wrong prefix nack", a, 0);
    busStop();

    // R6 upper write and pointer follow-on
    writeByte(8'h90, 8'h5A, 1'b0, "R6 data ack");
    expectByte(8'h5A, "R6 readback");
    readSeq(8'h90, 1);
    expectByte(8'hFF, "R6 current address read");
    currentRead();

    // R5 wrap from 0xFF to 0x00
    writeByte(8'hFF, 8'h11, 1'b0, "R6 data ack top");
    expectByte(8'h11, "R5 last byte");
    expectByte(8'h80, "R5 wrapped to byte0");
    readSeq(8'hFF, 2);

    // R7 second data byte rejected
    busStart();
    sendByte(DEV_WR, 1'b0, a);
    sendByte(8'hA0, 1'b0, a);
    sendByte(8'h01, 1'b0, a);
    check(a, "R7 first data ack", a, 1);
    sendByte(8'h02, 1'b0, a);
    check(!a, "R7 second data nack", a, 0);
    busStop();
    expectByte(8'h01, "R7 first byte kept");
    expectByte(8'hFF, "R7 second byte not stored");
    readSeq(8'hA0, 2);

    // R12 STOP in the middle of a byte
    busStart();
    clockBit(1'b1, 1'b0, s);
    clockBit(1'b0, 1'b0, s);
    clockBit(1'b1, 1'b0, s);
    clockBit(1'b0, 1'b0, s);
    busStop();
    expectByte(8'h08, "R12 read after aborted byte");
    readSeq(8'h01, 1);

    // R8 lower half writable before lock, R11 checksum flag
    writeByte(8'h05, 8'h33, 1'b0, "R8 data ack");
    expectByte(8'h33, "R8 lower readback");
    readSeq(8'h05, 1);
    check(checksumBad == 1'b1, "R11 mismatch flagged", checksumBad, 1);
    writeByte(8'd63, 8'hD9, 1'b0, "R11 checksum rewrite ack");
    waitC(4);
    check(checksumBad == 1'b0, "R11 mismatch cleared", checksumBad, 0);

    // R10 lock arrives in the commit cycle of a lower write
    writeByte(8'h06, 8'h77, 1'b1, "R10 data ack");
    expectByte(8'h00, "R10 lock wins");
    readSeq(8'h06, 1);

    // R9 locked lower rejected, upper still open
    writeByte(8'h07, 8'h44, 1'b0, "R9 locked write ack");
    expectByte(8'h00, "R9 lower unchanged");
    readSeq(8'h07, 1);
    writeByte(8'h81, 8'hC3, 1'b0, "R9 upper write ack");
    expectByte(8'hC3, "R9 upper writable");
    readSeq(8'h81, 1);
    check(checksumBad == 1'b0, "R9 checksum still clean", checksumBad, 0);

    check(glitches == 0, "R4 data stable while clock high", glitches, 0);

    while (obsQ.size() != 0) @(negedge clk);
    waitC(2);
    check(expQ.size() == 0, "R5 all expected bytes seen", expQ.size(), 0);
    finishRun();
  end

endmodule